// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether an I/O access of one, two or four consecutive ports may go ahead. A request carries the starting port number, an access-size code, the current privilege level and the I/O privilege level. When the current level is numerically at or below the I/O privilege level, the access is granted at once. Otherwise the block looks up one permission bit per covered port in a byte-wide bitmap memory. It reaches that memory through a read port with one cycle of latency.

The bitmap sits at a configurable byte offset. A configurable limit names the last byte offset that may be read. Bytes past that limit are never read and count as all-ones. Each accepted request gets exactly one response, either grant or fault, marked by a one-cycle done strobe. A host holds a request with valid until ready is seen. It then waits for done before it acts on the outcome.

Top module: `iopm_checker`

## Requirements
- R1: If the current privilege level is numerically less than or equal to the I/O privilege level, the request is granted without any bitmap read, and done is high in the cycle after acceptance.
- R2: If the current privilege level is numerically greater, the bitmap is consulted. Done comes 3 cycles after acceptance when the covered bits lie in one byte, and 5 cycles after when they span two bytes.
- R3: Permission bit n sits in the byte at offset base + n/8, at bit position n mod 8. A bit value of 0 allows the port and a value of 1 denies it.
- R4: The size code selects the number of covered ports: 0 selects 1, 1 selects 2, and 2 or 3 select 4. Every covered bit is checked, and one set bit denies the whole access.
- R5: When the covered bits cross a byte boundary, both bytes are read (two reads) and both take part in the decision.
- R6: A byte whose offset is greater than the configured limit is not read and is treated as all ones, so any covered bit in it denies the access.
- R7: Bit indices above 0xFFFF (reached by multi-port accesses starting near port 0xFFFF) map to bytes past offset base + 0x1FFF and obey the same limit rule.
- R8: Ready is high only while the block is idle. Each accepted request yields exactly one done pulse one cycle wide. With done, exactly one of grant and fault is high, and both are low at all other times.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_port | input | 16 | First port number of the access |
| req_size | input | 2 | Access size code (0: 1 port, 1: 2 ports, 2/3: 4 ports) |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level |
| cfg_map_base | input | 16 | Byte offset of bitmap bit 0 |
| cfg_map_limit | input | 16 | Last readable byte offset |
| mem_rd_en | output | 1 | Bitmap read strobe |
| mem_rd_addr | output | 17 | Bitmap byte offset to read |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_grant | output | 1 | Access permitted (with done) |
| rsp_fault | output | 1 | Protection fault (with done) |

## Verification
Two functions can meet in one decision: the limit rule and the bitmap bit lookup. This happens when a two-port access crosses a byte boundary and only its second byte lies past the limit. The bench sets the limit to the first byte's offset, leaves that byte clear, and expects a fault after a single read and five cycles. It repeats this at the top of the port range, where the second byte sits past offset base + 0x1FFF. The response strobe and a new request can also overlap. The bench holds valid through the done cycles and expects done never to be high on two cycles in a row.

// File: rtl/iopm_pkg.sv
package iopm_pkg;

   typedef enum logic [1:0] {
      SZ_ONE  = 2'd0,
      SZ_TWO  = 2'd1,
      SZ_FOUR = 2'd2,
      SZ_RSVD = 2'd3
   } access_size_e;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FETCH   = 2'd1,
      ST_COLLECT = 2'd2,
      ST_RESP    = 2'd3
   } chk_state_e;

   // R4: bit run covered by an access, right-aligned
   function automatic logic [3:0] run_mask(input logic [1:0] sz);
      case (sz)
         SZ_ONE:  run_mask = 4'b0001;
         SZ_TWO:  run_mask = 4'b0011;
         default: run_mask = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/iopm_priv_cmp.sv
module iopm_priv_cmp #(
   parameter int PL_W = 2
) (
   input  logic [PL_W-1:0] cur_level,
   input  logic [PL_W-1:0] io_level,
   output logic            bypass
);
   // R1: numerically lower or equal level is privileged enough
   always_comb bypass = (cur_level <= io_level);
endmodule

// File: rtl/iopm_span.sv
module iopm_span
   import iopm_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int OFF_W  = 16,
   parameter int ADDR_W = OFF_W + 1
) (
   input  logic [PORT_W-1:0]        port,
   input  logic [1:0]               size,
   input  logic [OFF_W-1:0]         map_base,
   input  logic [OFF_W-1:0]         map_limit,
   output logic [1:0][ADDR_W-1:0]   lane_addr,
   output logic [1:0][7:0]          lane_mask,
   output logic [1:0]               lane_inlim,
   output logic                     crosses
);
   localparam int LANES = 2;
   localparam int WIN_W = 8 * LANES;

   logic [ADDR_W-1:0] first_byte;
   logic [WIN_W-1:0]  window;

   // R3: byte = base + n/8, position = n mod 8
   always_comb begin
      first_byte = ADDR_W'(map_base) + ADDR_W'(port >> 3);
      window     = WIN_W'(run_mask(size)) << port[2:0];
      crosses    = |window[WIN_W-1:8];
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         lane_addr[g]  = first_byte + ADDR_W'(g);
         lane_mask[g]  = window[8*g +: 8];
         // R6 / R7: bytes past the limit are not readable
         lane_inlim[g] = (lane_addr[g] <= ADDR_W'(map_limit));
      end
   end
endmodule

// File: rtl/iopm_checker.sv
module iopm_checker
   import iopm_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int OFF_W  = 16,
   parameter int PL_W   = 2,
   parameter int ADDR_W = OFF_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PORT_W-1:0] req_port,
   input  logic [1:0]        req_size,
   input  logic [PL_W-1:0]   req_cpl,
   input  logic [PL_W-1:0]   req_iopl,
   input  logic [OFF_W-1:0]  cfg_map_base,
   input  logic [OFF_W-1:0]  cfg_map_limit,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              rsp_done,
   output logic              rsp_grant,
   output logic              rsp_fault
);
   if (PL_W < 1) begin : g_bad_pl
      $error("PL_W must be at least 1");
   end
   if (PORT_W - 3 > OFF_W) begin : g_bad_off
      $error("OFF_W too narrow for PORT_W");
   end
   if (ADDR_W < OFF_W + 1) begin : g_bad_addr
      $error("ADDR_W must exceed OFF_W");
   end

   chk_state_e         st;
   logic               lane;
   logic               deny;
   logic [PORT_W-1:0]  port_q;
   logic [1:0]         size_q;
   logic               bypass;
   logic               hit;
   logic               accept;

   logic [1:0][ADDR_W-1:0] lane_addr;
   logic [1:0][7:0]        lane_mask;
   logic [1:0]             lane_inlim;
   logic                   crosses;

   iopm_priv_cmp #(.PL_W(PL_W)) u_priv (
      .cur_level (req_cpl),
      .io_level  (req_iopl),
      .bypass    (bypass)
   );

   iopm_span #(.PORT_W(PORT_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_span (
      .port       (port_q),
      .size       (size_q),
      .map_base   (cfg_map_base),
      .map_limit  (cfg_map_limit),
      .lane_addr  (lane_addr),
      .lane_mask  (lane_mask),
      .lane_inlim (lane_inlim),
      .crosses    (crosses)
   );

   always_comb begin
      req_ready   = (st == ST_IDLE);
      accept      = req_valid && req_ready;
      mem_rd_en   = (st == ST_FETCH) && lane_inlim[lane];
      mem_rd_addr = lane_addr[lane];
      rsp_done    = (st == ST_RESP);
      rsp_grant   = rsp_done && !deny;
      rsp_fault   = rsp_done && deny;
      // R4 / R6: unreadable byte counts as all ones
      hit = lane_inlim[lane] ? |(mem_rd_data & lane_mask[lane])
                             : |lane_mask[lane];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         lane   <= 1'b0;
         deny   <= 1'b0;
         port_q <= '0;
         size_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid) begin
               port_q <= req_port;
               size_q <= req_size;
               deny   <= 1'b0;
               lane   <= 1'b0;
               st     <= bypass ? ST_RESP : ST_FETCH;
            end
            ST_FETCH: st <= ST_COLLECT;
            ST_COLLECT: begin
               deny <= deny | hit;
               if (!lane && crosses) begin
                  lane <= 1'b1;
                  st   <= ST_FETCH;
               end else begin
                  st   <= ST_RESP;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_bypass_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_cpl <= req_iopl)) |=> (rsp_done && rsp_grant && !mem_rd_en));

   assert_slow_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_cpl > req_iopl)) |=> (!rsp_done && !req_ready));

   assert_no_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_en);

   assert_read_in_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_rd_addr <= ADDR_W'(cfg_map_limit)));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));

   assert_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_grant, rsp_fault}) && ((rsp_grant || rsp_fault) == rsp_done));
endmodule

// File: tb/iopm_checker_tb.sv
module iopm_checker_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_port = '0;
   logic [1:0]  req_size = '0;
   logic [1:0]  req_cpl = '0;
   logic [1:0]  req_iopl = '0;
   logic [15:0] cfg_map_base = 16'h0010;
   logic [15:0] cfg_map_limit = 16'hFFFF;
   logic        mem_rd_en;
   logic [16:0] mem_rd_addr;
   logic [7:0]  mem_rd_data = '0;
   logic        rsp_done, rsp_grant, rsp_fault;

   logic [7:0]  tbmem [64];
   int          rd_cnt = 0;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iopm_checker u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_port(req_port), .req_size(req_size), .req_cpl(req_cpl), .req_iopl(req_iopl),
      .cfg_map_base(cfg_map_base), .cfg_map_limit(cfg_map_limit),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .rsp_done(rsp_done), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
   );

   always_ff @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= tbmem[mem_rd_addr[5:0]];
         rd_cnt      <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int n_ports(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   task automatic fill(input logic [7:0] v);
      for (int i = 0; i < 64; i++) tbmem[i] = v;
   endtask

   task automatic do_req(input logic [15:0] port, input logic [1:0] sz,
                         input logic [1:0] cpl, input logic [1:0] iopl, input string tag);
      int    n, lat, rd0, exp_lat, exp_rd;
      bit    exp_deny, two;
      logic [16:0] b, a, a0, a1;
      n = n_ports(sz);
      exp_deny = 1'b0;
      for (int i = 0; i < n; i++) begin
         b = 17'(port) + 17'(i);
         a = 17'(cfg_map_base) + (b >> 3);
         if (a > 17'(cfg_map_limit)) exp_deny = 1'b1;
         else if (tbmem[a[5:0]][b[2:0]]) exp_deny = 1'b1;
      end
      a0  = 17'(cfg_map_base) + 17'(port >> 3);
      a1  = a0 + 17'd1;
      two = (int'(port[2:0]) + n - 1) > 7;
      if (cpl <= iopl) begin
         exp_deny = 1'b0; exp_lat = 1; exp_rd = 0;
      end else begin
         exp_lat = two ? 5 : 3;
         exp_rd  = (a0 <= 17'(cfg_map_limit)) ? 1 : 0;
         if (two && a1 <= 17'(cfg_map_limit)) exp_rd++;
      end
      @(negedge clk);
      req_port = port; req_size = sz; req_cpl = cpl; req_iopl = iopl; req_valid = 1'b1;
      chk(req_ready == 1'b1, {tag, " R8 ready idle"}, int'(req_ready), 1);
      rd0 = rd_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_done && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
      chk(rsp_fault == exp_deny && rsp_grant == !exp_deny, {tag, " outcome"},
          int'(rsp_fault), int'(exp_deny));
      chk(rd_cnt - rd0 == exp_rd, {tag, " reads"}, rd_cnt - rd0, exp_rd);
      @(negedge clk);
      chk(!rsp_done && req_ready, {tag, " R8 single pulse"}, int'(rsp_done), 0);
   endtask

   task automatic t_reset();
      chk(req_ready && !rsp_done && !rsp_grant && !rsp_fault && !mem_rd_en,
          "R8 reset state", int'({req_ready, rsp_done, rsp_grant, rsp_fault, mem_rd_en}), 16);
   endtask

   task automatic t_priv();
      fill(8'hFF);
      do_req(16'h0003, 2'd0, 2'd0, 2'd0, "R1 equal zero");
      do_req(16'h0010, 2'd2, 2'd2, 2'd3, "R1 below");
      do_req(16'hFFFE, 2'd2, 2'd3, 2'd3, "R1 equal three");
   endtask

   task automatic t_byte();
      fill(8'h00);
      tbmem[16] = 8'b0010_0000;
      do_req(16'h0005, 2'd0, 2'd3, 2'd0, "R3 set bit denies");
      do_req(16'h0004, 2'd0, 2'd3, 2'd0, "R3 clear bit grants");
      do_req(16'h0005, 2'd0, 2'd3, 2'd2, "R2 cpl above iopl");
   endtask

   task automatic t_size();
      fill(8'h00);
      tbmem[16] = 8'b0010_0000;
      do_req(16'h0004, 2'd1, 2'd3, 2'd0, "R4 two ports deny");
      do_req(16'h0006, 2'd1, 2'd3, 2'd0, "R4 two ports grant");
      do_req(16'h0000, 2'd2, 2'd3, 2'd0, "R4 four ports grant");
      do_req(16'h0002, 2'd2, 2'd3, 2'd0, "R4 four ports deny");
      do_req(16'h0002, 2'd3, 2'd3, 2'd0, "R4 code three deny");
   endtask

   task automatic t_cross();
      fill(8'h00);
      tbmem[17] = 8'b0000_0001;
      do_req(16'h0007, 2'd1, 2'd1, 2'd0, "R5 cross second byte deny");
      do_req(16'h0006, 2'd2, 2'd1, 2'd0, "R5 cross four deny");
      tbmem[17] = 8'b0000_0010;
      do_req(16'h0007, 2'd1, 2'd1, 2'd0, "R5 cross grant");
   endtask

   task automatic t_limit();
      fill(8'h00);
      cfg_map_limit = 16'h0010;
      do_req(16'h0007, 2'd1, 2'd3, 2'd0, "R6 second byte past limit");
      do_req(16'h0008, 2'd0, 2'd3, 2'd0, "R6 byte past limit");
      do_req(16'h0007, 2'd0, 2'd3, 2'd0, "R6 last byte in limit");
      cfg_map_limit = 16'hFFFF;
   endtask

   task automatic t_wrap();
      fill(8'h00);
      cfg_map_limit = 16'h200F;
      do_req(16'hFFFE, 2'd2, 2'd3, 2'd0, "R7 high bits past limit");
      cfg_map_limit = 16'h2010;
      do_req(16'hFFFE, 2'd2, 2'd3, 2'd0, "R7 high bits in limit grant");
      tbmem[16] = 8'b0000_0010;
      do_req(16'hFFFE, 2'd2, 2'd3, 2'd0, "R7 high bit set deny");
      cfg_map_limit = 16'hFFFF;
   endtask

   task automatic t_held();
      int  dones;
      bit  prev, dbl;
      dones = 0; prev = 1'b0; dbl = 1'b0;
      @(negedge clk);
      req_port = 16'h0001; req_size = 2'd0; req_cpl = 2'd0; req_iopl = 2'd3;
      req_valid = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (rsp_done) dones++;
         if (rsp_done && prev) dbl = 1'b1;
         prev = rsp_done;
      end
      req_valid = 1'b0;
      chk(dones == 3, "R8 held valid done count", dones, 3);
      chk(!dbl, "R8 held valid no back to back done", int'(dbl), 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      fill(8'h00);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_priv();
      t_byte();
      t_size();
      t_cross();
      t_limit();
      t_wrap();
      t_held();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule